// File: doc/BRIEF.md
# Truth-Table Programmable State Machine

This block is a small sequential cell. Three 16-bit truth-table words and a 2-bit mode field set all of its behaviour. Two of the words give the next value of each state bit. The third word gives the combinational output. The cell takes two event inputs, `ev_in[1:0]`, and two auxiliary inputs, `aux_in[1:0]`. It drives its two state bits and one output bit.

The mode field selects one of three operations:
- a single machine whose state is the 2-bit pair (s1, s0);
- two separate one-bit machines, each of which sees only its own state bit;
- a plain 4-input look-up table, in which the auxiliary inputs take the place of the state bits and the state is held cleared.

A simple write port loads each configuration register. The host selects a register, drives the data and raises a write strobe for one clock cycle. Reset is asynchronous and active-low. Inside the block its release is synchronised to the clock.

Top module: `tt_fsm`

## Requirements
- R1: While reset is asserted, and after it is released, the state bits are 00, all three table words are 0 and the mode is look-up (0), so the output is 0.
- R2: A write with `cfg_sel` = 0 loads the state-bit-0 table, 1 loads the state-bit-1 table, 2 loads the output table, and 3 loads the mode from `cfg_wdata[1:0]`. A written value is in effect from the clock edge that accepts it.
- R3: In mode 1 (single four-state machine), each state bit k takes, on the clock edge, bit i of its own table, where i = {s1, s0, e1, e0} and e0 is the least significant bit.
- R4: In mode 2 (two machines), state bit 0 takes bit {0, s0, e1, e0} of its table and state bit 1 takes bit {0, s1, e1, e0} of its table, so neither bit depends on the other.
- R5: In modes 1 and 2 the output is bit {s1, s0, e1, e0} of the output table, combinationally.
- R6: In mode 0 or 3 (look-up), the output is bit {x1, x0, e1, e0} of the output table, where x1 and x0 are `aux_in[1:0]`, and both state bits are 00 after the next clock edge.
- R7: In modes 1 and 2 the auxiliary inputs have no effect on the output or on the state.
- R8: When a configuration write and a state update fall on the same clock edge, the update uses the table and mode values held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 = next0 table, 1 = next1 table, 2 = output table, 3 = mode |
| cfg_wdata | input | 16 | Configuration write data |
| ev_in | input | 2 | Event inputs e1, e0 |
| aux_in | input | 2 | Auxiliary inputs x1, x0, used in look-up mode |
| state_out | output | 2 | Registered state bits s1, s0 |
| y_out | output | 1 | Combinational output |

## Verification
A configuration write and a state update can happen on the same clock edge. In that case the machine steps using the old table while the new one is being stored. The bench provokes this by rewriting the next-state tables and the mode in the middle of a running sequence, with the write strobe raised in the same cycle as live event inputs. A reference model computes the next state from the tables held before the write, applies the write afterwards, and then compares the state bits and the output on the following cycle.

// File: rtl/tt_fsm_pkg.sv
package tt_fsm_pkg;
  localparam int IDX_W = 4;
  localparam int TBL_W = 1 << IDX_W;
  localparam int ST_W  = 2;

  typedef enum logic [1:0] {
    MODE_LUT     = 2'd0,
    MODE_QUAD    = 2'd1,
    MODE_PAIR    = 2'd2,
    MODE_LUT_ALT = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    SEL_NEXT0 = 2'd0,
    SEL_NEXT1 = 2'd1,
    SEL_OUT   = 2'd2,
    SEL_MODE  = 2'd3
  } sel_e;

  function automatic logic is_state_mode(mode_e m);
    return (m == MODE_QUAD) || (m == MODE_PAIR);
  endfunction
endpackage

// File: rtl/tt_rst_sync.sv
module tt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tt_table.sv
module tt_table #(
  parameter int IDX_W = 4,
  localparam int TBL_W = 1 << IDX_W
) (
  input  logic [TBL_W-1:0] word,
  input  logic [IDX_W-1:0] idx,
  output logic             bit_o
);
  // Binary mux tree: level l reduces 2^(IDX_W-l) candidates by index bit l.
  logic [TBL_W-1:0] lvl [IDX_W+1];

  assign lvl[0] = word;

  for (genvar l = 0; l < IDX_W; l++) begin : g_lvl
    localparam int N = TBL_W >> (l + 1);
    always_comb begin
      lvl[l+1] = '0;
      for (int j = 0; j < N; j++) begin
        lvl[l+1][j] = idx[l] ? lvl[l][2*j+1] : lvl[l][2*j];
      end
    end
  end

  assign bit_o = lvl[IDX_W][0];
endmodule

// File: rtl/tt_cfg_regs.sv
module tt_cfg_regs
  import tt_fsm_pkg::*;
#(
  parameter int W = TBL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [1:0]   cfg_sel,
  input  logic [W-1:0] cfg_wdata,
  output logic [W-1:0] next0_word,
  output logic [W-1:0] next1_word,
  output logic [W-1:0] out_word,
  output mode_e        mode
);
  localparam int NWORDS = 3;

  logic [W-1:0] word_q [NWORDS];
  logic [W-1:0] word_d [NWORDS];
  logic         word_en [NWORDS];
  logic [1:0]   mode_q, mode_d;
  logic         mode_en;

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    always_comb begin
      word_en[i] = cfg_we && (cfg_sel == 2'(i));
      word_d[i]  = word_en[i] ? cfg_wdata : word_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          word_q[i] <= '0;
      else if (word_en[i]) word_q[i] <= word_d[i];
    end
  end

  always_comb begin
    mode_en = cfg_we && (sel_e'(cfg_sel) == SEL_MODE);
    mode_d  = mode_en ? cfg_wdata[1:0] : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 2'(MODE_LUT);
    else if (mode_en) mode_q <= mode_d;
  end

  assign next0_word = word_q[SEL_NEXT0];
  assign next1_word = word_q[SEL_NEXT1];
  assign out_word   = word_q[SEL_OUT];
  assign mode       = mode_e'(mode_q);

  // R2
  out_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'(SEL_OUT)) |=> (out_word == $past(cfg_wdata)));

  // R2
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'(SEL_MODE)) |=> (2'(mode) == $past(cfg_wdata[1:0])));
endmodule

// File: rtl/tt_state.sv
module tt_state
  import tt_fsm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  mode_e            mode,
  input  logic [TBL_W-1:0] next0_word,
  input  logic [TBL_W-1:0] next1_word,
  input  logic [1:0]       ev,
  output logic [ST_W-1:0]  state
);
  logic [ST_W-1:0]  s_q, s_d, raw;
  logic [TBL_W-1:0] tbl [ST_W];
  logic [IDX_W-1:0] idx [ST_W];
  logic             run;
  logic             upd_en;

  assign tbl[0] = next0_word;
  assign tbl[1] = next1_word;

  for (genvar b = 0; b < ST_W; b++) begin : g_bit
    always_comb begin
      if (mode == MODE_PAIR) idx[b] = {1'b0, s_q[b], ev};
      else                   idx[b] = {s_q, ev};
    end

    tt_table #(.IDX_W(IDX_W)) u_next (
      .word (tbl[b]),
      .idx  (idx[b]),
      .bit_o(raw[b])
    );
  end

  always_comb begin
    run    = is_state_mode(mode);
    s_d    = run ? raw : '0;
    upd_en = run || (s_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      s_q <= '0;
    else if (upd_en) s_q <= s_d;
  end

  assign state = s_q;

  // R6
  lut_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_state_mode(mode)) |=> (s_q == '0));

  // R4
  pair_iso0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PAIR) |=> (s_q[0] == $past(next0_word[{1'b0, s_q[0], ev}])));

  // R4
  pair_iso1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PAIR) |=> (s_q[1] == $past(next1_word[{1'b0, s_q[1], ev}])));

  // R3
  quad_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_QUAD) |=> (s_q == {$past(next1_word[{s_q, ev}]), $past(next0_word[{s_q, ev}])}));
endmodule

// File: rtl/tt_fsm.sv
module tt_fsm
  import tt_fsm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [TBL_W-1:0] cfg_wdata,
  input  logic [1:0]       ev_in,
  input  logic [1:0]       aux_in,
  output logic [ST_W-1:0]  state_out,
  output logic             y_out
);
  logic             rst_n_sync;
  logic [TBL_W-1:0] next0_word, next1_word, out_word;
  mode_e            mode;
  logic [ST_W-1:0]  state;
  logic [IDX_W-1:0] out_idx;

  tt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_sync)
  );

  tt_cfg_regs u_cfg (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .next0_word(next0_word),
    .next1_word(next1_word),
    .out_word  (out_word),
    .mode      (mode)
  );

  tt_state u_state (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .mode      (mode),
    .next0_word(next0_word),
    .next1_word(next1_word),
    .ev        (ev_in),
    .state     (state)
  );

  always_comb begin
    if (is_state_mode(mode)) out_idx = {state, ev_in};
    else                     out_idx = {aux_in, ev_in};
  end

  tt_table #(.IDX_W(IDX_W)) u_out (
    .word (out_word),
    .idx  (out_idx),
    .bit_o(y_out)
  );

  assign state_out = state;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    (!rst_n_sync) |-> (state_out == '0));

  // R7
  aux_blind_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (is_state_mode(mode) && $stable(mode) && $stable(state_out) && $stable(ev_in)
     && $stable(out_word)) |-> $stable(y_out));
endmodule

// File: tb/tt_fsm_test.sv
`timescale 1ns/1ps
module tt_fsm_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic [1:0]  ev_in = '0;
  logic [1:0]  aux_in = '0;
  logic [1:0]  state_out;
  logic        y_out;

  int vectors = 0;
  int fails = 0;

  logic [15:0] m_n0, m_n1, m_y;
  logic [1:0]  m_mode, m_s;

  always #2.5 clk = ~clk;

  tt_fsm uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ev_in(ev_in), .aux_in(aux_in),
    .state_out(state_out), .y_out(y_out)
  );

  function automatic logic [15:0] mk(int a);
    return 16'((a * 40503 + 7) ^ (a << 7) ^ (a * a * 31));
  endfunction

  task automatic check(input logic [1:0] act, input logic [1:0] exp, input string req);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Called just after a falling edge; returns just after the next falling edge.
  task automatic step(input logic [1:0] ev, input logic [1:0] xv,
                      input bit wr, input logic [1:0] sel, input logic [15:0] d);
    logic [1:0] nx;
    logic       ey;
    string      st_req;
    ev_in = ev; aux_in = xv;
    cfg_we = wr; cfg_sel = sel; cfg_wdata = d;
    #1;
    if (m_mode == 2'd1 || m_mode == 2'd2) ey = m_y[{m_s, ev}];
    else                                  ey = m_y[{xv, ev}];
    check({1'b0, y_out}, {1'b0, ey},
          (m_mode == 2'd1 || m_mode == 2'd2) ? "R5/R7 output" : "R6 lut output");
    // next state from tables held before any write (R8)
    case (m_mode)
      2'd1:    nx = {m_n1[{m_s, ev}], m_n0[{m_s, ev}]};
      2'd2:    nx = {m_n1[{1'b0, m_s[1], ev}], m_n0[{1'b0, m_s[0], ev}]};
      default: nx = 2'b00;
    endcase
    st_req = wr ? "R8 same-edge" : (m_mode == 2'd1) ? "R3 quad" :
             (m_mode == 2'd2) ? "R4 pair" : "R6 lut clear";
    if (wr) begin
      case (sel)
        2'd0: m_n0 = d;
        2'd1: m_n1 = d;
        2'd2: m_y  = d;
        default: m_mode = d[1:0];
      endcase
    end
    m_s = nx;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    check(state_out, m_s, st_req);
  endtask

  task automatic wr_cfg(input logic [1:0] sel, input logic [15:0] d);
    step(2'b00, 2'b00, 1'b1, sel, d);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    m_n0 = '0; m_n1 = '0; m_y = '0; m_mode = '0; m_s = '0;
    repeat (2) @(negedge clk);
    #1;
    // R1 reset state during reset
    check(state_out, 2'b00, "R1 reset state");
    check({1'b0, y_out}, 2'b00, "R1 reset output");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(state_out, 2'b00, "R1 after release");
    for (int v = 0; v < 16; v++) begin
      aux_in = v[3:2]; ev_in = v[1:0];
      #0.2;
      check({1'b0, y_out}, 2'b00, "R1 zero tables");
    end

    // R2 output table load visible in lookup mode
    wr_cfg(2'd2, 16'hA5C3);
    for (int v = 0; v < 16; v++) step(v[1:0], v[3:2], 1'b0, 2'd0, 16'h0);

    for (int mi = 0; mi < 4; mi++) begin
      logic [1:0] md;
      md = (mi == 0) ? 2'd1 : (mi == 1) ? 2'd2 : (mi == 2) ? 2'd0 : 2'd3;
      for (int c = 0; c < 8; c++) begin
        int seed;
        seed = mi * 8 + c + 1;
        wr_cfg(2'd0, mk(seed));
        wr_cfg(2'd1, mk(seed + 100));
        wr_cfg(2'd2, mk(seed + 200));
        wr_cfg(2'd3, {14'h0, md});
        for (int k = 0; k < 64; k++) begin
          int h;
          h = (k * 7 + c * 3 + (k >> 2)) & 15;
          // R8: every 16th step rewrites a table on the stepping edge
          if ((k & 15) == 9)
            step(h[1:0], h[3:2], 1'b1, 2'(k >> 4 & 1), mk(seed * 3 + k));
          else
            step(h[1:0], h[3:2], 1'b0, 2'd0, 16'h0);
        end
      end
    end

    // R8 mode change on a stepping edge: quad -> lut mid-run
    wr_cfg(2'd0, 16'hFFFF); wr_cfg(2'd1, 16'hFFFF); wr_cfg(2'd3, 16'h0001);
    step(2'b01, 2'b10, 1'b0, 2'd0, 16'h0);
    step(2'b11, 2'b01, 1'b1, 2'd3, 16'h0000);
    step(2'b10, 2'b11, 1'b0, 2'd0, 16'h0);

    // R1 asynchronous reset in mid-run
    wr_cfg(2'd3, 16'h0001);
    step(2'b00, 2'b00, 1'b0, 2'd0, 16'h0);
    rst_n = 1'b0;
    #1;
    m_s = '0; m_n0 = '0; m_n1 = '0; m_y = '0; m_mode = '0;
    check(state_out, 2'b00, "R1 async reset");
    check({1'b0, y_out}, 2'b00, "R1 reset output");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(state_out, 2'b00, "R1 post reset");
    step(2'b11, 2'b11, 1'b0, 2'd0, 16'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule